// File: doc/BRIEF.md
# Multi-Slope Exposure Sequencer

This block times the exposure of a pixel array that uses up to three integration slopes. Each frame opens with three pixel reset pulses held high. A line counter then runs on a line-rate strobe. Each reset pulse drops on the line chosen by its own programmed threshold. The internal sample pulse rises on the line chosen by a fourth threshold and stays high for a fixed number of clock cycles set by a two-bit granularity input. Three window outputs show the total, double-slope and triple-slope integration spans. Each window is high from the fall of its own reset pulse to the fall of the sample pulse. A fixed overhead period follows, and then the next frame starts.

The counter restarts at the start of every frame. In normal mode it starts at 1 and steps by 1, so a threshold of N+1 gives N lines of delay. In subsampling mode it starts at 2 and steps by 2, so thresholds must be even. The block raises an error flag whenever subsampling is selected together with an odd threshold. All settings are copied into shadow registers at frame start, so they may be rewritten at any time.

The control is a four-state machine:
- LOAD lasts one cycle. It captures the settings, restarts the counter and raises the resets. It always goes to EXPOSE.
- EXPOSE counts lines and drops the resets. It goes to SAMPLE once the sample condition holds.
- SAMPLE holds the sample pulse for its length. It goes to OVERHEAD when its timer expires.
- OVERHEAD waits for the overhead period. It goes back to LOAD when its timer expires.

Top module: `its_integ_seq`

## Requirements
- R1: While `rst_n` is low, every output is low. The first rising clock edge with `rst_n` high starts a frame.
- R2: In normal mode (`subsample_en`=0 at frame start), the counter is 1 at frame start and rises by 1 on each `line_tick`. A reset pulse drops in the cycle after the counter first reaches a value at or above its threshold.
- R3: In subsampling mode (`subsample_en`=1 at frame start), the counter starts at 2 and rises by 2 on each `line_tick`.
- R4: `pix_reset[1]` never drops before `pix_reset[0]`, and `pix_reset[2]` never drops before `pix_reset[1]`. A pulse whose threshold is already met drops on the same edge as its predecessor.
- R5: `win_total`, `win_dual` and `win_triple` rise on the same edge on which `pix_reset[0]`, `pix_reset[1]` and `pix_reset[2]` drop. All three windows fall on the edge on which `sample_pulse` falls.
- R6: `sample_pulse` rises once all three resets are low and the counter is at or above `xfer_line`. This can happen on the same edge as the last reset drop.
- R7: `sample_pulse` stays high for 4*(12*(G+1)+2) cycles, where G is the `sample_gran` value at frame start: 56, 104, 152 or 200 cycles.
- R8: After `sample_pulse` falls, the resets rise again OVH_CYCLES+1 cycles later, which starts the next frame.
- R9: Changes to the threshold, mode and granularity inputs made after a frame has started do not affect that frame.
- R10: `odd_cfg_err` is high one cycle after `subsample_en` is high while bit 0 of any of the four thresholds is 1. Otherwise it is low one cycle later.
- R11: All three resets rise together on the edge that starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle strobe per line period |
| subsample_en | input | 1 | Selects subsampling mode |
| sample_gran | input | 2 | Sample pulse granularity |
| rst_a_line | input | LINE_W | Threshold for the total reset pulse |
| rst_b_line | input | LINE_W | Threshold for the double-slope reset pulse |
| rst_c_line | input | LINE_W | Threshold for the triple-slope reset pulse |
| xfer_line | input | LINE_W | Threshold for the sample pulse rise |
| pix_reset | output | 3 | Pixel reset pulses, bit 0 total, bit 1 double, bit 2 triple |
| sample_pulse | output | 1 | Internal pixel sample pulse |
| win_total | output | 1 | Total integration window |
| win_dual | output | 1 | Double-slope integration window |
| win_triple | output | 1 | Triple-slope integration window |
| odd_cfg_err | output | 1 | Odd threshold while subsampling |

## Verification
The assertions assume the following about the inputs:
- `line_tick` is a single-cycle strobe.
- The thresholds are small enough that the counter never saturates before `xfer_line` is reached.
- `rst_n` is applied asynchronously from time zero.

The stimulus keeps within these limits. It pulses `line_tick` once every seven cycles and uses thresholds well below the counter range. It programs even values in every frame that runs in subsampling mode. Odd values with subsampling appear only as mid-frame scramble writes. Those writes must be hidden by the shadow registers and must still raise the error flag.

// File: rtl/its_pkg.sv
package its_pkg;

    typedef enum logic [1:0] {
        ST_LOAD     = 2'd0,
        ST_EXPOSE   = 2'd1,
        ST_SAMPLE   = 2'd2,
        ST_OVERHEAD = 2'd3
    } its_state_e;

    localparam int SAMPLE_MAX = 200;

    // sample pulse length in clock cycles for a granularity code
    function automatic logic [7:0] sample_cycles(input logic [1:0] g);
        logic [7:0] gx;
        gx = {6'd0, g} + 8'd1;
        return 8'd4 * (8'd12 * gx + 8'd2);
    endfunction

endpackage

// File: rtl/its_line_counter.sv
module its_line_counter #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sub_mode,
    input  logic              advance,
    input  logic              tick,
    output logic [LINE_W-1:0] cnt
);

    localparam logic [LINE_W-1:0] TOP = '1;

    logic [LINE_W-1:0] step;
    logic [LINE_W-1:0] headroom;
    logic              sat;

    // start value equals the step: 1 in normal mode, 2 when subsampling
    assign step     = sub_mode ? LINE_W'(2) : LINE_W'(1);
    assign headroom = TOP - cnt;
    assign sat      = headroom < step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= step;
        end else if (advance && tick) begin
            cnt <= sat ? TOP : cnt + step;
        end
    end

    // R2 / R3: restart value follows the mode
    p_line_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == ($past(sub_mode) ? LINE_W'(2) : LINE_W'(1))));

    // R2: each accepted tick moves the counter by one step
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && tick && !load && !sat) |=> (cnt == $past(cnt) + $past(step)));

endmodule

// File: rtl/its_down_timer.sv
module its_down_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             done
);

    logic [TMR_W-1:0] val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (val != '0) begin
            val <= val - 1'b1;
        end
    end

    assign done = (val == '0);

endmodule

// File: rtl/its_event_chain.sv
module its_event_chain #(
    parameter int LINE_W = 10,
    parameter int N_EV   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_start,
    input  logic                         run,
    input  logic                         frame_end,
    input  logic [LINE_W-1:0]            cnt,
    input  logic [N_EV-1:0][LINE_W-1:0]  thr,
    output logic [N_EV-1:0]              rst_q,
    output logic [N_EV-1:0]              win_q,
    output logic                         clear_now
);

    logic [N_EV-1:0] fall;
    logic [N_EV-1:0] prior_ok;

    generate
        for (genvar k = 0; k < N_EV; k++) begin : g_ev
            logic r_q;
            logic w_q;

            if (k == 0) begin : g_first
                assign prior_ok[k] = 1'b1;
            end else begin : g_next
                // a later pulse may drop only with or after its predecessor
                assign prior_ok[k] = !rst_q[k-1] || fall[k-1];

                // R4: reset pulses drop in order
                p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    rst_q[k-1] |-> rst_q[k]);
            end

            assign fall[k] = run && r_q && prior_ok[k] && (cnt >= thr[k]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= 1'b0;
                    w_q <= 1'b0;
                end else if (frame_start) begin
                    r_q <= 1'b1;
                    w_q <= 1'b0;
                end else if (frame_end) begin
                    w_q <= 1'b0;
                end else if (fall[k]) begin
                    r_q <= 1'b0;
                    w_q <= 1'b1;
                end
            end

            assign rst_q[k] = r_q;
            assign win_q[k] = w_q;

            // R5: a window is open only after its reset has dropped
            p_win_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
                w_q |-> !r_q);
        end
    endgenerate

    assign clear_now = &(~rst_q | fall);

endmodule

// File: rtl/its_integ_seq.sv
module its_integ_seq
    import its_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int OVH_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              subsample_en,
    input  logic [1:0]        sample_gran,
    input  logic [LINE_W-1:0] rst_a_line,
    input  logic [LINE_W-1:0] rst_b_line,
    input  logic [LINE_W-1:0] rst_c_line,
    input  logic [LINE_W-1:0] xfer_line,
    output logic [2:0]        pix_reset,
    output logic              sample_pulse,
    output logic              win_total,
    output logic              win_dual,
    output logic              win_triple,
    output logic              odd_cfg_err
);

    localparam int N_EV    = 3;
    localparam int TMR_MAX = (OVH_CYCLES > SAMPLE_MAX) ? OVH_CYCLES : SAMPLE_MAX;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    its_state_e state, nxt;

    // shadow copies taken in LOAD
    logic [LINE_W-1:0]           a_sh, b_sh, c_sh, x_sh;
    logic                        sub_sh;
    logic [1:0]                  gran_sh;
    logic [N_EV-1:0][LINE_W-1:0] thr;

    logic [LINE_W-1:0] cnt;
    logic              cnt_mode;
    logic              clear_now;
    logic              go;
    logic              tmr_done;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              frame_end;
    logic [N_EV-1:0]   rst_q;
    logic [N_EV-1:0]   win_q;
    logic              sample_q;
    logic              odd_in;
    logic              odd_q;

    assign thr       = {c_sh, b_sh, a_sh};
    assign cnt_mode  = (state == ST_LOAD) ? subsample_en : sub_sh;
    assign go        = (state == ST_EXPOSE) && clear_now && (cnt >= x_sh);
    assign frame_end = (state == ST_SAMPLE) && tmr_done;
    assign tmr_load  = go || frame_end;
    assign tmr_val   = go ? TMR_W'(sample_cycles(gran_sh) - 8'd1)
                          : TMR_W'(OVH_CYCLES - 1);
    assign odd_in    = rst_a_line[0] | rst_b_line[0] | rst_c_line[0] | xfer_line[0];

    its_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_LOAD),
        .sub_mode (cnt_mode),
        .advance  (state == ST_EXPOSE),
        .tick     (line_tick),
        .cnt      (cnt)
    );

    its_event_chain #(.LINE_W(LINE_W), .N_EV(N_EV)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (state == ST_LOAD),
        .run         (state == ST_EXPOSE),
        .frame_end   (frame_end),
        .cnt         (cnt),
        .thr         (thr),
        .rst_q       (rst_q),
        .win_q       (win_q),
        .clear_now   (clear_now)
    );

    its_down_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD:     nxt = ST_EXPOSE;
            ST_EXPOSE:   if (go)       nxt = ST_SAMPLE;
            ST_SAMPLE:   if (tmr_done) nxt = ST_OVERHEAD;
            ST_OVERHEAD: if (tmr_done) nxt = ST_LOAD;
            default:     nxt = ST_LOAD;
        endcase
    end

    // registered outputs and shadow capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sh     <= '0;
            b_sh     <= '0;
            c_sh     <= '0;
            x_sh     <= '0;
            sub_sh   <= 1'b0;
            gran_sh  <= 2'd0;
            sample_q <= 1'b0;
            odd_q    <= 1'b0;
        end else begin
            odd_q <= subsample_en & odd_in;
            unique case (state)
                ST_LOAD: begin
                    a_sh    <= rst_a_line;
                    b_sh    <= rst_b_line;
                    c_sh    <= rst_c_line;
                    x_sh    <= xfer_line;
                    sub_sh  <= subsample_en;
                    gran_sh <= sample_gran;
                end
                ST_EXPOSE:   if (go)       sample_q <= 1'b1;
                ST_SAMPLE:   if (tmr_done) sample_q <= 1'b0;
                ST_OVERHEAD: sample_q <= 1'b0;
                default:     sample_q <= 1'b0;
            endcase
        end
    end

    assign pix_reset    = rst_q;
    assign sample_pulse = sample_q;
    assign win_total    = win_q[0];
    assign win_dual     = win_q[1];
    assign win_triple   = win_q[2];
    assign odd_cfg_err  = odd_q;

    // R1: quiet outputs under reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (rst_q == '0 && win_q == '0 && !sample_q && !odd_q);
        end
    end

    // R6: sample only after every reset has dropped
    p_sample_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_q |-> (rst_q == '0));

    // R5: windows close with the sample pulse
    p_win_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_q) |-> (win_q == '0));

    // R9: shadow settings hold outside LOAD
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |=> ($stable(x_sh) && $stable(sub_sh) && $stable(gran_sh)));

    // R10: odd threshold flag follows its inputs by one cycle
    p_odd_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (subsample_en && odd_in) |=> odd_cfg_err);

endmodule

// File: tb/tb_its_integ_seq.sv
module tb_its_integ_seq;

    localparam int LINE_W = 10;
    localparam int OVH    = 16;
    localparam int NFR    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_tick = 1'b0;
    logic              subsample_en = 1'b0;
    logic [1:0]        sample_gran = 2'd0;
    logic [LINE_W-1:0] rst_a_line = '0;
    logic [LINE_W-1:0] rst_b_line = '0;
    logic [LINE_W-1:0] rst_c_line = '0;
    logic [LINE_W-1:0] xfer_line = '0;
    logic [2:0]        pix_reset;
    logic              sample_pulse;
    logic              win_total, win_dual, win_triple;
    logic              odd_cfg_err;

    always #2 clk = ~clk;   // 250 MHz

    its_integ_seq #(.LINE_W(LINE_W), .OVH_CYCLES(OVH)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_tick    (line_tick),
        .subsample_en (subsample_en),
        .sample_gran  (sample_gran),
        .rst_a_line   (rst_a_line),
        .rst_b_line   (rst_b_line),
        .rst_c_line   (rst_c_line),
        .xfer_line    (xfer_line),
        .pix_reset    (pix_reset),
        .sample_pulse (sample_pulse),
        .win_total    (win_total),
        .win_dual     (win_dual),
        .win_triple   (win_triple),
        .odd_cfg_err  (odd_cfg_err)
    );

    typedef struct {
        int kind;
        int val;
    } item_t;

    item_t expq[$];
    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int ca[NFR], cb[NFR], cc[NFR], cx[NFR], cg[NFR];
    bit cs[NFR];

    int frame_starts = 0;
    int sample_falls = 0;

    function automatic int first_ge(int th, int st, int sp);
        if (th <= st) return st;
        return st + sp * ((th - st + sp - 1) / sp);
    endfunction

    function automatic string req_of(int kind);
        case (kind)
            0, 1, 2: return "R2/R3/R4/R5/R11 reset drop line";
            3:       return "R6 sample rise line";
            4:       return "R7/R5 sample width";
            default: return "R8 frame overhead gap";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_cfg(int i);
        rst_a_line   = LINE_W'(ca[i]);
        rst_b_line   = LINE_W'(cb[i]);
        rst_c_line   = LINE_W'(cc[i]);
        xfer_line    = LINE_W'(cx[i]);
        sample_gran  = 2'(cg[i]);
        subsample_en = cs[i];
    endtask

    // driver side of the scoreboard: expected events of frame i, in tick units
    task automatic push_frame(int i, bit with_gap);
        int st, sp, l1, l2, l3, ls;
        st = cs[i] ? 2 : 1;
        sp = st;
        l1 = first_ge(ca[i], st, sp);
        l2 = first_ge((cb[i] > l1) ? cb[i] : l1, st, sp);
        l3 = first_ge((cc[i] > l2) ? cc[i] : l2, st, sp);
        ls = first_ge((cx[i] > l3) ? cx[i] : l3, st, sp);
        expq.push_back('{0, (l1 - st) / sp});
        expq.push_back('{1, (l2 - st) / sp});
        expq.push_back('{2, (l3 - st) / sp});
        expq.push_back('{3, (ls - st) / sp});
        expq.push_back('{4, 4 * (12 * (cg[i] + 1) + 2)});
        if (with_gap) expq.push_back('{5, OVH + 1});
    endtask

    // mid-frame scramble: must not affect the running frame (R9)
    task automatic scramble();
        rst_a_line   = LINE_W'(7);
        rst_b_line   = LINE_W'(3);
        rst_c_line   = LINE_W'(1);
        xfer_line    = LINE_W'(40);
        sample_gran  = 2'd3;
        subsample_en = 1'b1;
    endtask

    task automatic observe(int kind, int val);
        item_t e;
        if (expq.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL %s actual=%0d expected=none", req_of(kind), val);
            return;
        end
        e = expq.pop_front();
        check(req_of(kind), kind * 100000 + val, e.kind * 100000 + e.val);
    endtask

    // line strobe: one cycle in seven
    initial begin
        forever begin
            repeat (6) @(negedge clk);
            line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
        end
    end

    // monitor side of the scoreboard
    logic [2:0] prev_rst = '0;
    logic       prev_smp = 1'b0;
    logic [2:0] prev_win = '0;
    int cyc = 0;
    int s1 = 0;
    int s2 = 0;
    int rise_cyc = 0;
    int fall_cyc = 0;
    bit have_fall = 0;

    always @(negedge clk) begin
        logic [2:0] win_now;
        cyc++;
        win_now = {win_triple, win_dual, win_total};
        if (rst_n && !finished) begin
            if (pix_reset[0] && !prev_rst[0]) begin
                // R11: all resets rise together
                check("R11 resets rise together", int'(pix_reset), 7);
                if (have_fall) observe(5, cyc - fall_cyc);
                have_fall = 0;
                frame_starts++;
                s1 = 0;
            end
            for (int k = 0; k < 3; k++) begin
                if (!pix_reset[k] && prev_rst[k])
                    observe(k, (win_now[k] && !prev_win[k]) ? s2 : -1000);
            end
            if (sample_pulse && !prev_smp) begin
                observe(3, s2);
                rise_cyc = cyc;
            end
            if (!sample_pulse && prev_smp) begin
                observe(4, (win_now != 3'b000) ? -1 : cyc - rise_cyc);
                fall_cyc = cyc;
                have_fall = 1;
                sample_falls++;
            end
        end
        s2 = s1;
        s1 = s1 + int'(line_tick);
        prev_rst = pix_reset;
        prev_smp = sample_pulse;
        prev_win = win_now;
    end

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        // normal mode, spread thresholds (R2)
        ca[0] = 3;  cb[0] = 6;  cc[0] = 8;  cx[0] = 12; cg[0] = 0; cs[0] = 0;
        // subsampling, even thresholds (R3)
        ca[1] = 4;  cb[1] = 8;  cc[1] = 10; cx[1] = 14; cg[1] = 1; cs[1] = 1;
        // all equal: same-edge chain (R4, R6)
        ca[2] = 5;  cb[2] = 5;  cc[2] = 5;  cx[2] = 5;  cg[2] = 2; cs[2] = 0;
        // reversed order: later pulses wait for earlier ones (R4)
        ca[3] = 9;  cb[3] = 4;  cc[3] = 2;  cx[3] = 6;  cg[3] = 3; cs[3] = 0;
        // thresholds at or below the start value
        ca[4] = 0;  cb[4] = 1;  cc[4] = 2;  cx[4] = 3;  cg[4] = 0; cs[4] = 0;
        // subsampling with thresholds at the start value
        ca[5] = 2;  cb[5] = 6;  cc[5] = 6;  cx[5] = 10; cg[5] = 0; cs[5] = 1;

        apply_cfg(0);
        push_frame(0, 1);
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 pix_reset in reset", int'(pix_reset), 0);
        check("R1 sample in reset", int'(sample_pulse), 0);
        check("R1 windows in reset", int'({win_triple, win_dual, win_total}), 0);
        check("R1 odd flag in reset", int'(odd_cfg_err), 0);
        rst_n = 1'b1;

        wait (frame_starts == 1);
        scramble();
        @(negedge clk);
        check("R10 odd flag on scramble", int'(odd_cfg_err), 1);

        for (int i = 1; i < NFR; i++) begin
            wait (sample_falls == i);
            apply_cfg(i);
            push_frame(i, i < NFR - 1);
            @(negedge clk);
            check("R10 odd flag after program", int'(odd_cfg_err), 0);
            wait (frame_starts == i + 1);
            scramble();
            @(negedge clk);
            check("R10 odd flag on scramble", int'(odd_cfg_err), 1);
        end

        wait (sample_falls == NFR);
        @(negedge clk);
        check("R2 scoreboard drained", expq.size(), 0);
        summary();
    end

endmodule